// File: doc/BRIEF.md
# UART Out-of-Band Flow Control Unit

This unit sits beside a UART datapath and runs its request-to-send / clear-to-send handshake. On the receive side it raises RTS, telling the remote end to stop sending, whenever the local receiver is switched off or the receive DMA buffer has been reported full. RTS drops again once software hands the DMA a fresh buffer. On the transmit side it synchronises the incoming CTS pin and grants permission to begin a new character only while CTS is low. It never interrupts a character that has already started.

Both directions are controlled only when the mode field holds the handshake code. In every other mode RTS stays low and CTS has no effect on transmission. Independent of mode, every CTS transition is captured in a sticky status flag. That flag can be masked onto an interrupt line and is cleared by a status-clear strobe.

Top module: `uart_flow_ctrl`

## Requirements
- R1: Handshaking is active only when `mode` (4 bits) equals the handshake code 4'h2; `mode` changes take effect on the next clock for RTS and at once for transmit permission.
- R2: In handshake mode, with `rx_enable` low, `rts_o` is high one clock after the input is sampled; with `rx_enable` high and no buffer-full condition, `rts_o` is low one clock later.
- R3: A `buf_full_set` pulse in handshake mode makes `rts_o` high two clocks after the pulse is sampled, and it stays high while no reallocation follows.
- R4: A `buf_realloc` pulse clears the buffer-full condition, so `rts_o` returns low two clocks later when the receiver is enabled; when `buf_full_set` and `buf_realloc` arrive in the same cycle, the full condition is kept.
- R5: `tx_start_ok` is high only when `tx_pending` is high, `tx_busy` is low and, in handshake mode, the synchronised CTS is low; a change on `cts_pin` reaches `tx_start_ok` after two clocks.
- R6: Outside handshake mode, `rts_o` is low and `tx_start_ok` follows `tx_pending` and `!tx_busy` whatever the CTS level.
- R7: Each CTS transition, rising or falling, sets `cts_change` three clocks after the pin moves, and the flag stays set until cleared.
- R8: `status_clr` clears `cts_change` on the next clock; when a CTS edge is detected in the same cycle as the clear, the flag is set.
- R9: `irq` is high exactly while `cts_change` and `irq_en` are both high.
- R10: During reset `rts_o` is high, `cts_change` and `irq` are low, and the synchronised CTS reads high, so `tx_start_ok` is low in handshake mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode | input | 4 | Operating mode; 4'h2 selects handshaking |
| rx_enable | input | 1 | Receiver enabled |
| buf_full_set | input | 1 | Pulse: receive DMA buffer is full |
| buf_realloc | input | 1 | Pulse: new receive buffer allocated |
| cts_pin | input | 1 | Asynchronous clear-to-send pin |
| tx_busy | input | 1 | Transmitter is shifting a character |
| tx_pending | input | 1 | Transmitter has a character waiting |
| status_clr | input | 1 | Clears the CTS change flag |
| irq_en | input | 1 | Interrupt enable for the CTS change flag |
| rts_o | output | 1 | Request-to-send pin, high means stop |
| tx_start_ok | output | 1 | Transmitter may start a new character |
| cts_change | output | 1 | Sticky CTS transition flag |
| irq | output | 1 | Interrupt request |

## Verification
Each result has a fixed latency. RTS follows `rx_enable` and `mode` after one clock and a buffer pulse after two. Transmit permission follows CTS after two clocks and the busy and pending inputs at once. The change flag follows the pin after three clocks, and the interrupt follows the flag and its enable at once. Every scenario drives its inputs on a falling edge and then waits the exact number of rising edges for that path. It checks both the cycle before the result is due, where the old value must still show, and the cycle it is due. Combinational paths are sampled a nanosecond after the input moves.

// File: rtl/flow_pkg.sv
package flow_pkg;
   localparam int unsigned MODE_W_DEF  = 4;
   localparam int unsigned HS_CODE_DEF = 2;
   localparam int unsigned SYNC_DEF    = 2;
endpackage

// File: rtl/flow_cts_sync.sv
module flow_cts_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic level,
   output logic changed
);
   localparam int unsigned TOP = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("flow_cts_sync: STAGES must be at least 2");
   end

   logic [TOP:0] chain_q;
   logic         prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
         prev_q  <= RST_VAL;
      end else begin
         chain_q <= {chain_q[TOP-1:0], pin};
         prev_q  <= chain_q[TOP];
      end
   end

   assign level   = chain_q[TOP];
   assign changed = chain_q[TOP] ^ prev_q;
endmodule

// File: rtl/flow_rts_gen.sv
module flow_rts_gen #(
   parameter bit RTS_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hs_on,
   input  logic rx_enable,
   input  logic full_set,
   input  logic full_clr,
   output logic rts
);
   logic full_q;
   logic rts_want;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        full_q <= 1'b0;
      else if (full_set) full_q <= 1'b1;
      else if (full_clr) full_q <= 1'b0;
   end

   assign rts_want = hs_on & (~rx_enable | full_q);

   if (RTS_REG) begin : g_reg
      logic rts_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rts_q <= 1'b1;
         else        rts_q <= rts_want;
      end
      assign rts = rts_q;
   end else begin : g_comb
      assign rts = rts_want;
   end
endmodule

// File: rtl/flow_cts_status.sv
module flow_cts_status (
   input  logic clk,
   input  logic rst_n,
   input  logic edge_seen,
   input  logic clr,
   input  logic int_en,
   output logic flag,
   output logic irq
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag_q <= 1'b0;
      else if (edge_seen) flag_q <= 1'b1;
      else if (clr)       flag_q <= 1'b0;
   end

   assign flag = flag_q;
   assign irq  = flag_q & int_en;
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl #(
   parameter int unsigned MODE_W      = flow_pkg::MODE_W_DEF,
   parameter int unsigned HS_CODE     = flow_pkg::HS_CODE_DEF,
   parameter int unsigned SYNC_STAGES = flow_pkg::SYNC_DEF,
   parameter bit          RTS_REG     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode,
   input  logic              rx_enable,
   input  logic              buf_full_set,
   input  logic              buf_realloc,
   input  logic              cts_pin,
   input  logic              tx_busy,
   input  logic              tx_pending,
   input  logic              status_clr,
   input  logic              irq_en,
   output logic              rts_o,
   output logic              tx_start_ok,
   output logic              cts_change,
   output logic              irq
);
   localparam logic [MODE_W-1:0] HS_VAL = MODE_W'(HS_CODE);

   if (HS_CODE >= (1 << MODE_W)) begin : g_bad_code
      $error("uart_flow_ctrl: HS_CODE does not fit in MODE_W bits");
   end

   logic hs_on;
   logic cts_level;
   logic cts_edge;

   assign hs_on = (mode == HS_VAL);

   flow_cts_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin     (cts_pin),
      .level   (cts_level),
      .changed (cts_edge)
   );

   flow_rts_gen #(.RTS_REG(RTS_REG)) u_rts (
      .clk       (clk),
      .rst_n     (rst_n),
      .hs_on     (hs_on),
      .rx_enable (rx_enable),
      .full_set  (buf_full_set),
      .full_clr  (buf_realloc),
      .rts       (rts_o)
   );

   flow_cts_status u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .edge_seen (cts_edge),
      .clr       (status_clr),
      .int_en    (irq_en),
      .flag      (cts_change),
      .irq       (irq)
   );

   assign tx_start_ok = tx_pending & ~tx_busy & ~(hs_on & cts_level);
endmodule

// File: rtl/flow_ctrl_checker.sv
module flow_ctrl_checker #(
   parameter int unsigned MODE_W      = 4,
   parameter int unsigned HS_CODE     = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          RTS_REG     = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [MODE_W-1:0] mode,
   input logic              rx_enable,
   input logic              buf_full_set,
   input logic              cts_pin,
   input logic              tx_busy,
   input logic              tx_pending,
   input logic              status_clr,
   input logic              irq_en,
   input logic              rts_o,
   input logic              tx_start_ok,
   input logic              cts_change,
   input logic              irq
);
   localparam logic [MODE_W-1:0] HS_VAL = MODE_W'(HS_CODE);

   logic [1:0] age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            age_q <= 2'd0;
      else if (age_q != 2'd3) age_q <= age_q + 2'd1;
   end

   wire ok1 = (age_q >= 2'd1);
   wire ok2 = (age_q >= 2'd2);
   wire hs  = (mode == HS_VAL);

   if (RTS_REG) begin : g_rts_chk
      p_rx_off_rts_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (ok1 && $past(hs && !rx_enable)) |-> rts_o);
      p_full_rts_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (ok2 && $past(buf_full_set, 2) && $past(hs)) |-> rts_o);
      p_off_mode_rts_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (ok1 && $past(!hs)) |-> !rts_o);
   end

   if (SYNC_STAGES == 2) begin : g_cts_chk
      p_cts_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (ok2 && hs && $past(cts_pin, 2)) |-> !tx_start_ok);
   end

   p_busy_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_busy |-> !tx_start_ok);
   p_off_mode_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!hs && tx_pending && !tx_busy) |-> tx_start_ok);
   p_sticky_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cts_change && !status_clr) |=> cts_change);
   p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (irq_en && cts_change));
endmodule

bind uart_flow_ctrl flow_ctrl_checker #(
   .MODE_W(MODE_W), .HS_CODE(HS_CODE), .SYNC_STAGES(SYNC_STAGES), .RTS_REG(RTS_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mode(mode), .rx_enable(rx_enable),
   .buf_full_set(buf_full_set), .cts_pin(cts_pin), .tx_busy(tx_busy),
   .tx_pending(tx_pending), .status_clr(status_clr), .irq_en(irq_en),
   .rts_o(rts_o), .tx_start_ok(tx_start_ok), .cts_change(cts_change), .irq(irq)
);

// File: tb/uart_flow_ctrl_tb.sv
`timescale 1ns/1ps
module uart_flow_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] mode = 4'h2;
   logic       rx_enable = 1'b0, buf_full_set = 1'b0, buf_realloc = 1'b0;
   logic       cts_pin = 1'b1, tx_busy = 1'b0, tx_pending = 1'b0;
   logic       status_clr = 1'b0, irq_en = 1'b0;
   logic       rts_o, tx_start_ok, cts_change, irq;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   uart_flow_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .rx_enable(rx_enable),
      .buf_full_set(buf_full_set), .buf_realloc(buf_realloc), .cts_pin(cts_pin),
      .tx_busy(tx_busy), .tx_pending(tx_pending), .status_clr(status_clr),
      .irq_en(irq_en), .rts_o(rts_o), .tx_start_ok(tx_start_ok),
      .cts_change(cts_change), .irq(irq)
   );

   task automatic chk(input logic act, input logic exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic clear_flag();
      status_clr = 1'b1; tick(1); status_clr = 1'b0;
   endtask

   task automatic t_reset();
      tick(3);
      chk(rts_o, 1'b1, "R10 rts high in reset");
      chk(cts_change, 1'b0, "R10 flag low in reset");
      chk(irq, 1'b0, "R10 irq low in reset");
      tx_pending = 1'b1; #1;
      chk(tx_start_ok, 1'b0, "R10 start blocked in reset");
      tx_pending = 1'b0;
      rst_n = 1'b1;
      tick(2);
   endtask

   task automatic t_rx_enable();
      rx_enable = 1'b1; tick(1);
      chk(rts_o, 1'b0, "R2 rts low with receiver on");
      rx_enable = 1'b0; tick(1);
      chk(rts_o, 1'b1, "R2 rts high with receiver off");
      rx_enable = 1'b1; tick(1);
      chk(rts_o, 1'b0, "R2 rts low again");
   endtask

   task automatic t_buf_full();
      buf_full_set = 1'b1; tick(1); buf_full_set = 1'b0;
      chk(rts_o, 1'b0, "R3 rts not yet high one clock after pulse");
      tick(1);
      chk(rts_o, 1'b1, "R3 rts high two clocks after pulse");
      tick(3);
      chk(rts_o, 1'b1, "R3 rts holds while buffer full");
      buf_realloc = 1'b1; tick(1); buf_realloc = 1'b0;
      chk(rts_o, 1'b1, "R4 rts still high one clock after realloc");
      tick(1);
      chk(rts_o, 1'b0, "R4 rts low two clocks after realloc");
      buf_full_set = 1'b1; buf_realloc = 1'b1; tick(1);
      buf_full_set = 1'b0; buf_realloc = 1'b0; tick(1);
      chk(rts_o, 1'b1, "R4 simultaneous set and realloc keeps full");
      buf_realloc = 1'b1; tick(1); buf_realloc = 1'b0; tick(1);
      chk(rts_o, 1'b0, "R4 later realloc clears");
   endtask

   task automatic t_tx_gate();
      tx_pending = 1'b1; #1;
      chk(tx_start_ok, 1'b0, "R5 start blocked while CTS high");
      cts_pin = 1'b0; tick(1);
      chk(tx_start_ok, 1'b0, "R5 CTS low not yet through synchroniser");
      tick(1);
      chk(tx_start_ok, 1'b1, "R5 start allowed two clocks after CTS low");
      tx_busy = 1'b1; #1;
      chk(tx_start_ok, 1'b0, "R5 no start while busy");
      cts_pin = 1'b1; tick(2);
      tx_busy = 1'b0; #1;
      chk(tx_start_ok, 1'b0, "R5 character done, CTS high blocks next");
      tx_pending = 1'b0; cts_pin = 1'b0; tick(2);
      chk(tx_start_ok, 1'b0, "R5 nothing pending, no start");
      tx_pending = 1'b1; #1;
      chk(tx_start_ok, 1'b1, "R5 pending with CTS low starts");
      cts_pin = 1'b1; tick(2);
      tx_pending = 1'b0;
   endtask

   task automatic t_mode_off();
      mode = 4'h0; rx_enable = 1'b0; tx_pending = 1'b1; #1;
      chk(tx_start_ok, 1'b1, "R6 CTS ignored outside handshake mode");
      tick(1);
      chk(rts_o, 1'b0, "R6 rts low outside handshake mode");
      mode = 4'h3; tick(1);
      chk(rts_o, 1'b0, "R1 other code leaves handshake off");
      mode = 4'h2; #1;
      chk(tx_start_ok, 1'b0, "R1 handshake code gates start at once");
      tick(1);
      chk(rts_o, 1'b1, "R1 handshake code drives rts next clock");
      rx_enable = 1'b1; tx_pending = 1'b0; tick(1);
   endtask

   task automatic t_cts_flag();
      tick(2); clear_flag();
      chk(cts_change, 1'b0, "R8 flag cleared");
      cts_pin = 1'b0; tick(2);
      chk(cts_change, 1'b0, "R7 flag not set two clocks after fall");
      tick(1);
      chk(cts_change, 1'b1, "R7 flag set three clocks after fall");
      tick(3);
      chk(cts_change, 1'b1, "R7 flag sticky");
      clear_flag();
      chk(cts_change, 1'b0, "R8 clear strobe clears");
      cts_pin = 1'b1; tick(3);
      chk(cts_change, 1'b1, "R7 rising edge sets flag");
      clear_flag();
   endtask

   task automatic t_race();
      cts_pin = 1'b0; tick(2);
      status_clr = 1'b1; tick(1);
      chk(cts_change, 1'b1, "R8 edge wins over clear");
      tick(1); status_clr = 1'b0;
      chk(cts_change, 1'b0, "R8 clear takes effect without edge");
   endtask

   task automatic t_irq();
      cts_pin = 1'b1; tick(3);
      chk(irq, 1'b0, "R9 irq masked when disabled");
      irq_en = 1'b1; #1;
      chk(irq, 1'b1, "R9 irq with flag and enable");
      clear_flag(); #1;
      chk(irq, 1'b0, "R9 irq drops with flag");
      irq_en = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_rx_enable();
      t_buf_full();
      t_tx_gate();
      t_mode_off();
      t_cts_flag();
      t_race();
      t_irq();
      finish_run();
   end

   initial begin
      #(8 * 20000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule